// File: doc/BRIEF.md
# SMM Address Strobe Selector

This block sits between a processor core's bus-cycle sequencer and the pins. Each time the core begins a bus cycle, the block decides which of two active-low address strobes to pulse. One is the ordinary strobe. The other is reserved for accesses that target the system-management memory window. The decision depends on four things: whether the core is in system-management mode, whether the cycle address lies inside the programmed window, whether the cycle is a code fetch or a data access, and a software-writable override bit.

The override bit exists so that a management handler can reach ordinary memory that sits underneath the management window. When the bit is set, in-window data reads and writes made in management mode go out on the ordinary strobe. Code fetches never follow the override, so code in ordinary memory under the window cannot be executed from management mode. The block raises an error flag when such a fetch is attempted with the override set.

All cycle inputs are captured on the clock edge where the start pulse is seen. The chosen strobe is low for exactly the following clock.

Top module: `smm_strobe_sel`

## Requirements
- R1: During reset and in the first clock after it, both strobes are high and the error flag is low. Reset clears the override bit, so the first in-window access in management mode uses the management strobe.
- R2: When the in-management flag is low at cycle start, the ordinary strobe is used for every address and every cycle kind, whatever the override bit holds.
- R3: In management mode with the override clear, an in-window fetch, read or write uses the management strobe.
- R4: In management mode, an access outside the window uses the ordinary strobe, whether it is a fetch or a data access.
- R5: In management mode with the override set, an in-window read or write uses the ordinary strobe.
- R6: In management mode with the override set, an in-window fetch still uses the management strobe, and the error flag is high in the same clock. The flag stays low for every other cycle.
- R7: An address is inside the window when base <= address and (address - base) < size. The window does not wrap past the top of the address space, and a size of zero gives an empty window.
- R8: After each start pulse, exactly one strobe is low, for the single clock that follows it. In every other clock both strobes are high and the error flag is low.
- R9: Driving the override write enable high loads the override data bit at that clock edge. A cycle that starts in the same clock is decided with the previous override value.
- R10: The in-management flag, address and kind are sampled at cycle start. A change to any of them after that start does not affect the strobe for that cycle.
- R11: The cycle-kind encoding is 00 fetch, 01 data read, 10 data write. The value 11 is treated as a data access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_start | input | 1 | One-clock pulse that starts a bus cycle |
| cyc_addr | input | AW | Address of the starting cycle |
| cyc_kind | input | 2 | Cycle kind: 00 fetch, 01 read, 10 write, 11 data |
| in_smm | input | 1 | Core is in system-management mode |
| rgn_base | input | AW | First address of the management window |
| rgn_size | input | AW | Size of the management window in bytes; 0 means empty |
| ovr_we | input | 1 | Write enable for the override bit |
| ovr_d | input | 1 | Value to load into the override bit |
| norm_strobe_n | output | 1 | Ordinary address strobe, active low |
| smm_strobe_n | output | 1 | Management address strobe, active low |
| fetch_err | output | 1 | Forbidden fetch under the override, high with the strobe |

## Verification
Two functions can meet in one clock: a write to the override bit and the start of a cycle. The bench provokes this by pulsing the write enable and the start pulse together on an in-window read in management mode. The strobe for that read must follow the old override value. The read that follows must follow the new value. The error flag and the management strobe also coincide on an in-window fetch with the override set, and the bench checks both outputs in that same clock.

// File: rtl/smmsel_pkg.sv
// Shared types for the SMM address strobe selector.
package smmsel_pkg;

    // Bus cycle kinds as presented by the core's sequencer.
    typedef enum logic [1:0] {
        CK_FETCH = 2'b00,
        CK_READ  = 2'b01,
        CK_WRITE = 2'b10,
        CK_DATA  = 2'b11
    } cyc_kind_e;

    // Decision for one cycle: which strobe, and whether the fetch is forbidden.
    typedef struct packed {
        logic use_smm;
        logic bad_fetch;
    } pick_t;

endpackage

// File: rtl/smmsel_region.sv
// Window hit test.
// Computes base <= addr && (addr - base) < size without forming base + size,
// so a window reaching the top of the address space never wraps around.
// Assumes: purely combinational, with all inputs stable during the start clock.
module smmsel_region #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] size,
    output logic          hit
);
    logic          at_or_above;
    logic [AW-1:0] offset;

    // Offset into the window, which is only meaningful when addr >= base.
    always_comb begin
        at_or_above = (addr >= base);
        offset      = addr - base;
        hit         = at_or_above && (offset < size);
    end
endmodule

// File: rtl/smmsel_ovr.sv
// Override bit register.
// Holds the control bit that sends in-window data accesses to ordinary memory.
// Assumes: single-bit write port; the value is cleared by synchronous reset.
module smmsel_ovr (
    input  logic clk,
    input  logic rst_n,
    input  logic we,
    input  logic d,
    output logic q
);
    // Load the override bit on write enable; clear it in reset.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= 1'b0;
        else if (we) q <= d;
    end

    // R9: a write takes effect at its own clock edge.
    assert_ovr_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(we) |-> q == $past(d));

    // R1: the bit is clear when reset is released.
    assert_ovr_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !q);
endmodule

// File: rtl/smmsel_decide.sv
// Strobe decision and output registers.
// Selects the management strobe for in-window accesses in management mode,
// except data accesses when the override is set. Fetches ignore the override,
// and a fetch attempted under the override is flagged.
// Assumes: start is a one-clock pulse; outputs are registered one clock later.
module smmsel_decide (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  in_smm,
    input  smmsel_pkg::cyc_kind_e kind,
    input  logic                  hit,
    input  logic                  ovr,
    output logic                  norm_n,
    output logic                  smm_n,
    output logic                  err
);
    import smmsel_pkg::*;

    pick_t pick;
    logic  is_fetch;

    // Form the per-cycle decision from mode, window hit, kind and override.
    always_comb begin
        is_fetch       = (kind == CK_FETCH);
        pick.use_smm   = in_smm && hit && (is_fetch || !ovr);
        pick.bad_fetch = in_smm && hit && is_fetch && ovr;
    end

    // Register the decision into a one-clock strobe; idle high otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            norm_n <= 1'b1;
            smm_n  <= 1'b1;
            err    <= 1'b0;
        end else if (start) begin
            norm_n <= pick.use_smm;
            smm_n  <= !pick.use_smm;
            err    <= pick.bad_fetch;
        end else begin
            norm_n <= 1'b1;
            smm_n  <= 1'b1;
            err    <= 1'b0;
        end
    end

    // R8: the two strobes are never low together.
    assert_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({~norm_n, ~smm_n}));

    // R8: a start is followed by exactly one low strobe.
    assert_one_after_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(start) |-> $countones({~norm_n, ~smm_n}) == 1);

    // R8: no start means idle outputs.
    assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(start) |-> norm_n && smm_n && !err);

    // R2: outside management mode the ordinary strobe is used.
    assert_normal_outside_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(start) && !$past(in_smm) |-> !norm_n);

    // R5: override sends in-window data accesses to the ordinary strobe.
    assert_ovr_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(start && in_smm && hit && ovr && (kind != CK_FETCH))
        |-> !norm_n);

    // R6: the error flag only rides on a management strobe.
    assert_err_with_smm_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !smm_n);
endmodule

// File: rtl/smm_strobe_sel.sv
// SMM address strobe selector, top level.
// Per bus cycle, pulses either the ordinary or the management address strobe
// for one clock after the start pulse, and flags fetches forbidden by the override.
// Assumes: cycle inputs are valid in the clock where cyc_start is high.
module smm_strobe_sel #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cyc_start,
    input  logic [AW-1:0] cyc_addr,
    input  logic [1:0]    cyc_kind,
    input  logic          in_smm,
    input  logic [AW-1:0] rgn_base,
    input  logic [AW-1:0] rgn_size,
    input  logic          ovr_we,
    input  logic          ovr_d,
    output logic          norm_strobe_n,
    output logic          smm_strobe_n,
    output logic          fetch_err
);
    import smmsel_pkg::*;

    logic      hit;
    logic      ovr_q;
    cyc_kind_e kind;

    // Interpret the raw kind field as the package enum.
    always_comb kind = cyc_kind_e'(cyc_kind);

    smmsel_region #(.AW(AW)) u_region (
        .addr (cyc_addr),
        .base (rgn_base),
        .size (rgn_size),
        .hit  (hit)
    );

    smmsel_ovr u_ovr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ovr_we),
        .d     (ovr_d),
        .q     (ovr_q)
    );

    smmsel_decide u_decide (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (cyc_start),
        .in_smm (in_smm),
        .kind   (kind),
        .hit    (hit),
        .ovr    (ovr_q),
        .norm_n (norm_strobe_n),
        .smm_n  (smm_strobe_n),
        .err    (fetch_err)
    );

    // R1: outputs are idle on the first clock after reset.
    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> norm_strobe_n && smm_strobe_n && !fetch_err);
endmodule

// File: tb/test_smm_strobe_sel.sv
`timescale 1ns/1ps
module test_smm_strobe_sel;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cyc_start = 1'b0;
    logic [AW-1:0] cyc_addr = '0;
    logic [1:0]    cyc_kind = 2'b00;
    logic          in_smm = 1'b0;
    logic [AW-1:0] rgn_base = '0;
    logic [AW-1:0] rgn_size = '0;
    logic          ovr_we = 1'b0;
    logic          ovr_d = 1'b0;
    logic          norm_strobe_n;
    logic          smm_strobe_n;
    logic          fetch_err;

    int n_vec = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    smm_strobe_sel #(.AW(AW)) i_smm_strobe_sel (
        .clk           (clk),
        .rst_n         (rst_n),
        .cyc_start     (cyc_start),
        .cyc_addr      (cyc_addr),
        .cyc_kind      (cyc_kind),
        .in_smm        (in_smm),
        .rgn_base      (rgn_base),
        .rgn_size      (rgn_size),
        .ovr_we        (ovr_we),
        .ovr_d         (ovr_d),
        .norm_strobe_n (norm_strobe_n),
        .smm_strobe_n  (smm_strobe_n),
        .fetch_err     (fetch_err)
    );

    // Layout: req[57:54] smm[53] ovr[52] kind[51:50] addr[49:34] base[33:18]
    // size[17:2] exp_smm_strobe[1] exp_err[0]
    localparam int NV = 17;
    localparam logic [57:0] VEC [NV] = '{
        {4'd2,  1'b0,1'b0,2'b00,16'h3000,16'h3000,16'h1000,1'b0,1'b0}, // R2 fetch in window
        {4'd2,  1'b0,1'b1,2'b00,16'h3100,16'h3000,16'h1000,1'b0,1'b0}, // R2 override set
        {4'd2,  1'b0,1'b0,2'b10,16'h0100,16'h3000,16'h1000,1'b0,1'b0}, // R2 write outside
        {4'd3,  1'b1,1'b0,2'b00,16'h3000,16'h3000,16'h1000,1'b1,1'b0}, // R3 fetch
        {4'd3,  1'b1,1'b0,2'b01,16'h3FFF,16'h3000,16'h1000,1'b1,1'b0}, // R3 read last byte
        {4'd3,  1'b1,1'b0,2'b10,16'h3800,16'h3000,16'h1000,1'b1,1'b0}, // R3 write
        {4'd7,  1'b1,1'b0,2'b01,16'h4000,16'h3000,16'h1000,1'b0,1'b0}, // R7 one past end
        {4'd4,  1'b1,1'b0,2'b00,16'h2FFF,16'h3000,16'h1000,1'b0,1'b0}, // R4 fetch below
        {4'd5,  1'b1,1'b1,2'b01,16'h3200,16'h3000,16'h1000,1'b0,1'b0}, // R5 read
        {4'd5,  1'b1,1'b1,2'b10,16'h3FFF,16'h3000,16'h1000,1'b0,1'b0}, // R5 write
        {4'd6,  1'b1,1'b1,2'b00,16'h3200,16'h3000,16'h1000,1'b1,1'b1}, // R6 forbidden fetch
        {4'd4,  1'b1,1'b1,2'b00,16'h5000,16'h3000,16'h1000,1'b0,1'b0}, // R4 fetch outside
        {4'd11, 1'b1,1'b0,2'b11,16'h3400,16'h3000,16'h1000,1'b1,1'b0}, // R11 kind 11
        {4'd11, 1'b1,1'b1,2'b11,16'h3400,16'h3000,16'h1000,1'b0,1'b0}, // R11 kind 11 as data
        {4'd7,  1'b1,1'b0,2'b00,16'h3000,16'h3000,16'h0000,1'b0,1'b0}, // R7 empty window
        {4'd7,  1'b1,1'b0,2'b01,16'hFFFF,16'hFF00,16'h0100,1'b1,1'b0}, // R7 top of space
        {4'd7,  1'b1,1'b0,2'b01,16'h0000,16'hF000,16'h2000,1'b0,1'b0}  // R7 no wrap
    };

    task automatic check(input int req, input logic act, input logic exp, input string what);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // Outputs for the strobe clock: ordinary or management strobe low, and error flag.
    task automatic check_out(input int req, input logic exp_smm, input logic exp_err);
        check(req, norm_strobe_n, exp_smm, "norm_strobe_n");
        check(req, smm_strobe_n, !exp_smm, "smm_strobe_n");
        check(req, fetch_err, exp_err, "fetch_err");
    endtask

    task automatic write_ovr(input logic v);
        @(negedge clk);
        ovr_we = 1'b1; ovr_d = v;
        @(negedge clk);
        ovr_we = 1'b0;
    endtask

    // Drive one cycle start; returns at the negedge where the strobe is visible.
    task automatic start_cycle(input logic smm, input logic [1:0] k, input logic [AW-1:0] a);
        @(negedge clk);
        in_smm = smm; cyc_kind = k; cyc_addr = a; cyc_start = 1'b1;
        @(negedge clk);
        cyc_start = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        rgn_base = 16'h3000; rgn_size = 16'h1000;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(1, norm_strobe_n, 1'b1, "norm_strobe_n in reset");
        check(1, smm_strobe_n, 1'b1, "smm_strobe_n in reset");
        check(1, fetch_err, 1'b0, "fetch_err in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(1, norm_strobe_n & smm_strobe_n, 1'b1, "idle after reset");
        // R1: override cleared, so in-window read uses the management strobe
        start_cycle(1'b1, 2'b01, 16'h3100);
        check_out(1, 1'b1, 1'b0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            rgn_base = VEC[i][33:18];
            rgn_size = VEC[i][17:2];
            write_ovr(VEC[i][52]);
            start_cycle(VEC[i][53], VEC[i][51:50], VEC[i][49:34]);
            check_out(int'(VEC[i][57:54]), VEC[i][1], VEC[i][0]);
            // R8: strobe lasts one clock only
            @(negedge clk);
            check(8, norm_strobe_n & smm_strobe_n & !fetch_err, 1'b1, "idle after strobe");
        end

        // R9: override write in the same clock as a start uses the old value
        rgn_base = 16'h3000; rgn_size = 16'h1000;
        write_ovr(1'b0);
        @(negedge clk);
        in_smm = 1'b1; cyc_kind = 2'b01; cyc_addr = 16'h3300;
        cyc_start = 1'b1; ovr_we = 1'b1; ovr_d = 1'b1;
        @(negedge clk);
        cyc_start = 1'b0; ovr_we = 1'b0;
        check_out(9, 1'b1, 1'b0);
        start_cycle(1'b1, 2'b01, 16'h3300);
        check_out(9, 1'b0, 1'b0);

        // R10: inputs change immediately after the start; decision keeps the start values
        write_ovr(1'b0);
        @(negedge clk);
        in_smm = 1'b1; cyc_kind = 2'b00; cyc_addr = 16'h3010; cyc_start = 1'b1;
        @(posedge clk);
        #1;
        cyc_start = 1'b0; in_smm = 1'b0; cyc_addr = 16'h9000;
        @(negedge clk);
        check_out(10, 1'b1, 1'b0);

        // R8: back-to-back starts give one strobe per clock
        @(negedge clk);
        in_smm = 1'b1; cyc_kind = 2'b01; cyc_addr = 16'h3020; cyc_start = 1'b1;
        @(negedge clk);
        cyc_addr = 16'h6000;
        check_out(8, 1'b1, 1'b0);
        @(negedge clk);
        cyc_start = 1'b0;
        check_out(8, 1'b0, 1'b0);
        @(negedge clk);
        check(8, norm_strobe_n & smm_strobe_n, 1'b1, "idle after pair");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule